// File: doc/BRIEF.md
# Raw NAND Bus Cycle Engine

This block is the register-driven front end of an 8-bit raw NAND flash port. A host writes command, address and data bytes into a small register file, and each such write becomes exactly one flash bus cycle. The block drives the command latch, address latch, write strobe, read strobe and chip select pins. A host read of the data register runs one read cycle on the flash bus and returns the byte that was captured.

Every cycle has four phases: setup, strobe, hold and a ready-wait tail. Each phase length comes from one 4-bit field of a timing register. Read cycles and write cycles use separate sets of fields. A host access that arrives while a cycle is still on the bus is held off by dropping `hostReady`.

The block also provides a synchronized ready/busy status bit, two interrupt events with enable and write-one-to-clear registers, a transfer counter that raises a done event, a chip-select hold bit, and a self-clearing soft reset.

Top module: `nand_if_top`

## Requirements
- R1: The timing register is at index 9. Its bits 31:28 are the write ready-wait field, 27:24 the write strobe width, 23:20 the write hold and 19:16 the write setup. A field value N makes its phase last N+1 clocks. In a write cycle `nandDoutEn` is high for the setup, strobe and hold phases, and `nandWeN` is low only during the strobe phase.
- R2: Bits 15:12 of the timing register are the read ready-wait field, 11:8 the read strobe width, 7:4 the read hold and 3:0 the read setup. In a read cycle `nandReN` is low for read-width+1 clocks.
- R3: A write to index 2 (command) runs one cycle with `nandCle` high and `nandAle` low. It puts bits 7:0 of the written word on `nandDout`.
- R4: A write to index 1 (address) runs one cycle with `nandAle` high and `nandCle` low. It puts bits 7:0 of the written word on `nandDout`.
- R5: A write to index 0 (data) runs one cycle with both latch pins low and bits 7:0 on `nandDout`. A read of index 0 runs one read cycle and returns the byte sampled on `nandDin` in bits 7:0, with bits 31:8 zero.
- R6: While bit 5 of the configuration register (index 4) is set, `nandCeN` stays low. While it is clear, `nandCeN` is low only while a cycle is active.
- R7: Bit 0 of the status register (index 5) follows `nandRdy` through a two-stage synchronizer. 1 means ready.
- R8: Bit 0 of the interrupt status register (index 6) is set by a rising edge of the synchronized ready line, not by its level. Writing 1s to index 8 clears the matching status bits. `irq` is the OR of the status bits ANDed with the enable register (index 7).
- R9: Index 10 holds a transfer count. Each completed data cycle decrements it while it is non-zero. The cycle that brings it from 1 to 0 sets interrupt status bit 1.
- R10: From the accepted write that launches a cycle, `hostReady` stays low for setup+width+hold+ready-wait+4 clocks. Writes are accepted in the clock they are presented while the bus is idle.
- R11: Writing a word with bit 2 set to the control register (index 3) returns the block to idle. It clears the configuration, interrupt enable, interrupt status and transfer count, and keeps the timing register. The control register always reads 0.
- R12: `nandWeN` and `nandReN` are never low together, and `nandCle` and `nandAle` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Host access request, held until accepted |
| hostWr | input | 1 | 1 for a write access, 0 for a read |
| hostAddr | input | 4 | Register index |
| hostWdata | input | 32 | Write data |
| hostReady | output | 1 | Access accepted in this clock when high with hostReq |
| hostRdata | output | 32 | Read data, valid when the access is accepted |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDout | output | 8 | Byte driven to the flash |
| nandDoutEn | output | 1 | Output enable for nandDout |
| nandDin | input | 8 | Byte returned by the flash |
| nandRdy | input | 1 | Ready/busy line from the flash, 1 = ready |
| irq | output | 1 | Interrupt request |

## Verification
The bus pins change one clock after the edge that accepts a write. After that, setup, strobe and hold last exactly N+1 clocks each. A monitor counts these phase lengths at falling clock edges and compares them with the scoreboard entry queued by the driver, together with the latch pins and the byte. The stall after a write must last the sum of all four fields plus four clocks, and the driver counts the idle-ready samples to check it. Status and interrupt bits are read only after the two synchronizer clocks and one register clock have passed. Reads that follow a bus cycle stall until the event register has settled.

// File: rtl/nand_pkg.sv
package nand_pkg;
  localparam int FIELD_W = 4;
  localparam int HALF_W  = 4 * FIELD_W;
  localparam int TIM_W   = 2 * HALF_W;
  localparam int CFG_W   = 6;
  localparam int CE_BIT  = 5;
  localparam int SRST_BIT = 2;
  localparam int IDX_W   = 4;

  localparam logic [IDX_W-1:0] REG_DATA   = 4'd0;
  localparam logic [IDX_W-1:0] REG_ADDR   = 4'd1;
  localparam logic [IDX_W-1:0] REG_CMD    = 4'd2;
  localparam logic [IDX_W-1:0] REG_CTRL   = 4'd3;
  localparam logic [IDX_W-1:0] REG_CFG    = 4'd4;
  localparam logic [IDX_W-1:0] REG_STAT   = 4'd5;
  localparam logic [IDX_W-1:0] REG_ISTAT  = 4'd6;
  localparam logic [IDX_W-1:0] REG_IEN    = 4'd7;
  localparam logic [IDX_W-1:0] REG_ICLR   = 4'd8;
  localparam logic [IDX_W-1:0] REG_TIMING = 4'd9;
  localparam logic [IDX_W-1:0] REG_XCOUNT = 4'd10;

  typedef enum logic [1:0] {KIND_CMD, KIND_ADDR, KIND_WDATA, KIND_RDATA} cycKind_e;

  typedef struct packed {
    logic     valid;
    cycKind_e kind;
  } launch_t;

  typedef struct packed {
    logic busy;
    logic capture;
    logic dataDone;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [FIELD_W-1:0] rdy;
    logic [FIELD_W-1:0] width;
    logic [FIELD_W-1:0] hold;
    logic [FIELD_W-1:0] setup;
  } phaseTime_t;
endpackage

// File: rtl/nand_cyc_ctrl.sv
module nand_cyc_ctrl
  import nand_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRst,
  input  launch_t     launch,
  input  phaseTime_t  wrTime,
  input  phaseTime_t  rdTime,
  output ctrlStrobe_t strobe,
  output logic        cle,
  output logic        ale,
  output logic        weN,
  output logic        reN,
  output logic        doutEn
);
  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_WAIT} phase_e;

  phase_e             state;
  cycKind_e           kindQ;
  logic [FIELD_W-1:0] cnt;
  phaseTime_t         curTime;
  phaseTime_t         startTime;
  logic               lastTick;
  logic               inPhase;
  logic               isRead;

  assign curTime   = (kindQ == KIND_RDATA) ? rdTime : wrTime;
  assign startTime = (launch.kind == KIND_RDATA) ? rdTime : wrTime;
  assign lastTick  = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kindQ <= KIND_CMD;
      cnt   <= '0;
    end else if (softRst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (launch.valid) begin
            state <= ST_SETUP;
            kindQ <= launch.kind;
            cnt   <= startTime.setup;
          end
        end
        ST_SETUP: begin
          if (lastTick) begin
            state <= ST_STROBE;
            cnt   <= curTime.width;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (lastTick) begin
            state <= ST_HOLD;
            cnt   <= curTime.hold;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (lastTick) begin
            state <= ST_WAIT;
            cnt   <= curTime.rdy;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WAIT: begin
          if (lastTick) state <= ST_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign isRead  = (kindQ == KIND_RDATA);
  assign inPhase = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);

  always_comb begin
    strobe          = '0;
    strobe.busy     = (state != ST_IDLE);
    strobe.capture  = (state == ST_STROBE) && lastTick && isRead;
    strobe.dataDone = (state == ST_WAIT) && lastTick &&
                      ((kindQ == KIND_WDATA) || isRead);
  end

  assign cle    = inPhase && (kindQ == KIND_CMD);
  assign ale    = inPhase && (kindQ == KIND_ADDR);
  assign weN    = !((state == ST_STROBE) && !isRead);
  assign reN    = !((state == ST_STROBE) && isRead);
  assign doutEn = inPhase && !isRead;
endmodule

// File: rtl/nand_regs_dp.sv
module nand_regs_dp
  import nand_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWr,
  input  logic [IDX_W-1:0]  hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostReady,
  output logic [DATA_W-1:0] hostRdata,
  input  ctrlStrobe_t       strobe,
  output launch_t           launch,
  output phaseTime_t        wrTime,
  output phaseTime_t        rdTime,
  output logic              softRst,
  output logic              ceN,
  output logic [7:0]        dout,
  input  logic [7:0]        din,
  input  logic              rdyIn,
  output logic              irq
);
  localparam int EV_W = 2;

  logic [CFG_W-1:0]       cfgQ;
  logic [TIM_W-1:0]       timingQ;
  logic [EV_W-1:0]        ienQ;
  logic [EV_W-1:0]        istatQ;
  logic [CNT_W-1:0]       xcountQ;
  logic [7:0]             rdByteQ;
  logic [7:0]             outByteQ;
  logic                   readDoneQ;
  logic                   rdyPrevQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rdySync;

  logic                   isRdData;
  logic                   accept;
  logic                   wrAcc;
  logic                   busWrite;
  logic [EV_W-1:0]        events;
  logic [EV_W-1:0]        clrMask;

  // ready/busy synchronizer, resets to "ready" so no event fires after reset
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= rdyIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate
  assign rdySync = syncQ[SYNC_STAGES-1];

  // host port decode
  assign isRdData  = hostReq && !hostWr && (hostAddr == REG_DATA);
  assign hostReady = !strobe.busy && !(isRdData && !readDoneQ);
  assign accept    = hostReq && hostReady;
  assign wrAcc     = accept && hostWr;
  assign busWrite  = wrAcc && ((hostAddr == REG_DATA) || (hostAddr == REG_ADDR) ||
                               (hostAddr == REG_CMD));
  assign softRst   = wrAcc && (hostAddr == REG_CTRL) && hostWdata[SRST_BIT];

  always_comb begin
    launch       = '0;
    launch.valid = busWrite || (isRdData && !readDoneQ && !strobe.busy);
    if (!hostWr)                      launch.kind = KIND_RDATA;
    else if (hostAddr == REG_CMD)     launch.kind = KIND_CMD;
    else if (hostAddr == REG_ADDR)    launch.kind = KIND_ADDR;
    else                              launch.kind = KIND_WDATA;
  end

  assign wrTime = phaseTime_t'(timingQ[TIM_W-1:HALF_W]);
  assign rdTime = phaseTime_t'(timingQ[HALF_W-1:0]);

  assign events[0] = rdySync && !rdyPrevQ;
  assign events[1] = strobe.dataDone && (xcountQ == CNT_W'(1));
  assign clrMask   = (wrAcc && (hostAddr == REG_ICLR)) ? hostWdata[EV_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ      <= '0;
      timingQ   <= '0;
      ienQ      <= '0;
      istatQ    <= '0;
      xcountQ   <= '0;
      rdByteQ   <= '0;
      outByteQ  <= '0;
      readDoneQ <= 1'b0;
      rdyPrevQ  <= 1'b1;
    end else begin
      rdyPrevQ <= rdySync;
      if (softRst) begin
        cfgQ      <= '0;
        ienQ      <= '0;
        istatQ    <= '0;
        xcountQ   <= '0;
        readDoneQ <= 1'b0;
      end else begin
        istatQ <= (istatQ & ~clrMask) | events;
        if (busWrite) outByteQ <= hostWdata[7:0];
        if (strobe.capture) begin
          rdByteQ   <= din;
          readDoneQ <= 1'b1;
        end else if (accept && isRdData) begin
          readDoneQ <= 1'b0;
        end
        if (wrAcc && (hostAddr == REG_CFG))    cfgQ    <= hostWdata[CFG_W-1:0];
        if (wrAcc && (hostAddr == REG_TIMING)) timingQ <= hostWdata[TIM_W-1:0];
        if (wrAcc && (hostAddr == REG_IEN))    ienQ    <= hostWdata[EV_W-1:0];
        if (wrAcc && (hostAddr == REG_XCOUNT))
          xcountQ <= hostWdata[CNT_W-1:0];
        else if (strobe.dataDone && (xcountQ != '0))
          xcountQ <= xcountQ - 1'b1;
      end
    end
  end

  always_comb begin
    hostRdata = '0;
    case (hostAddr)
      REG_DATA:   hostRdata[7:0]         = rdByteQ;
      REG_CFG:    hostRdata[CFG_W-1:0]   = cfgQ;
      REG_STAT:   hostRdata[0]           = rdySync;
      REG_ISTAT:  hostRdata[EV_W-1:0]    = istatQ;
      REG_IEN:    hostRdata[EV_W-1:0]    = ienQ;
      REG_TIMING: hostRdata[TIM_W-1:0]   = timingQ;
      REG_XCOUNT: hostRdata[CNT_W-1:0]   = xcountQ;
      default:    hostRdata              = '0;
    endcase
  end

  assign ceN  = !(cfgQ[CE_BIT] || strobe.busy);
  assign dout = outByteQ;
  assign irq  = |(istatQ & ienQ);
endmodule

// File: rtl/nand_if_top.sv
module nand_if_top
  import nand_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWr,
  input  logic [3:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostReady,
  output logic [DATA_W-1:0] hostRdata,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [7:0]        nandDout,
  output logic              nandDoutEn,
  input  logic [7:0]        nandDin,
  input  logic              nandRdy,
  output logic              irq
);
  ctrlStrobe_t strobe;
  launch_t     launch;
  phaseTime_t  wrTime;
  phaseTime_t  rdTime;
  logic        softRst;

  nand_regs_dp #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .hostReq(hostReq), .hostWr(hostWr), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostReady(hostReady), .hostRdata(hostRdata),
    .strobe(strobe), .launch(launch), .wrTime(wrTime), .rdTime(rdTime),
    .softRst(softRst), .ceN(nandCeN), .dout(nandDout), .din(nandDin),
    .rdyIn(nandRdy), .irq(irq)
  );

  nand_cyc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .launch(launch),
    .wrTime(wrTime), .rdTime(rdTime), .strobe(strobe),
    .cle(nandCle), .ale(nandAle), .weN(nandWeN), .reN(nandReN),
    .doutEn(nandDoutEn)
  );
endmodule

// File: rtl/nand_if_chk.sv
module nand_if_chk (
  input logic        clk,
  input logic        rstN,
  input logic        hostReq,
  input logic        hostWr,
  input logic [3:0]  hostAddr,
  input logic [31:0] hostWdata,
  input logic        hostReady,
  input logic        nandCeN,
  input logic        nandCle,
  input logic        nandAle,
  input logic        nandWeN,
  input logic        nandReN,
  input logic        nandDoutEn
);
  logic srstAcc;
  assign srstAcc = hostReq && hostReady && hostWr && (hostAddr == 4'd3) && hostWdata[2];

  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  assert_latch_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  assert_we_needs_ce_R6: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |-> !nandCeN);

  assert_we_drives_bus_R5: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |-> nandDoutEn);

  assert_stall_on_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN || !nandReN) |-> !hostReady);

  assert_soft_reset_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    srstAcc |=> (nandCeN && nandWeN && nandReN && !nandCle && !nandAle));
endmodule

bind nand_if_top nand_if_chk u_chk (
  .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWr(hostWr),
  .hostAddr(hostAddr), .hostWdata(hostWdata), .hostReady(hostReady),
  .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
  .nandWeN(nandWeN), .nandReN(nandReN), .nandDoutEn(nandDoutEn)
);

// File: tb/tb_nand_if_top.sv
`timescale 1ns/1ps
module tb_nand_if_top;
  import nand_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostWr = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic        hostReady;
  logic [31:0] hostRdata;
  logic        nandCeN, nandCle, nandAle, nandWeN, nandReN, nandDoutEn;
  logic [7:0]  nandDout;
  logic [7:0]  nandDin = 8'h00;
  logic        nandRdy = 1'b1;
  logic        irq;

  always #2 clk = ~clk;

  nand_if_top dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostReady(hostReady),
    .hostRdata(hostRdata), .nandCeN(nandCeN), .nandCle(nandCle),
    .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandDout(nandDout), .nandDoutEn(nandDoutEn), .nandDin(nandDin),
    .nandRdy(nandRdy), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      bad++; total++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", cyc, 60000);
      summary();
      $finish;
    end
  end

  // scoreboard items
  typedef struct {
    logic       cle;
    logic       ale;
    logic [7:0] b;
    int         su;
    int         lo;
    int         ho;
    string      tag;
  } wrItem_t;
  wrItem_t expQ[$];
  int      rdLowQ[$];

  int wS = 0, wW = 0, wH = 0, wR = 0;
  int rS = 0, rW = 0, rH = 0, rR = 0;

  // host driver
  task automatic hostWrite(input logic [3:0] a, input logic [31:0] d, output int stall);
    @(negedge clk);
    hostReq = 1'b1; hostWr = 1'b1; hostAddr = a; hostWdata = d;
    stall = 0;
    #1;
    while (!hostReady) begin
      stall++;
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    hostReq = 1'b0; hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    hostReq = 1'b1; hostWr = 1'b0; hostAddr = a;
    #1;
    while (!hostReady) begin
      @(negedge clk); #1;
    end
    d = hostRdata;
    @(posedge clk); #1;
    hostReq = 1'b0;
  endtask

  task automatic setTiming(input int ws, ww, wh, wr, rs, rw, rh, rr);
    int s;
    wS = ws; wW = ww; wH = wh; wR = wr; rS = rs; rW = rw; rH = rh; rR = rr;
    hostWrite(REG_TIMING, {wr[3:0], ww[3:0], wh[3:0], ws[3:0],
                           rr[3:0], rw[3:0], rh[3:0], rs[3:0]}, s);
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d, input string tag);
    wrItem_t it;
    int s;
    it.cle = (a == REG_CMD);
    it.ale = (a == REG_ADDR);
    it.b   = d[7:0];
    it.su  = wS + 1; it.lo = wW + 1; it.ho = wH + 1;
    it.tag = tag;
    expQ.push_back(it);
    hostWrite(a, d, s);
  endtask

  // monitor: phase lengths and pin values of each bus cycle
  int       mPre = 0, mLow = 0, mPost = 0, rLow = 0;
  bit       inSeg = 0, sawLow = 0, ceBad = 0, rIn = 0;
  logic     segCle, segAle;
  logic [7:0] segByte;

  always @(negedge clk) begin
    if (rstN) begin
      if (nandDoutEn) begin
        if (!inSeg) begin
          inSeg = 1; sawLow = 0; ceBad = 0; mPre = 0; mLow = 0; mPost = 0;
          segCle = nandCle; segAle = nandAle;
        end
        if (nandCeN) ceBad = 1;
        if (!nandWeN) begin
          mLow++; sawLow = 1; segByte = nandDout;
        end else if (!sawLow) mPre++;
        else mPost++;
      end else if (inSeg) begin
        wrItem_t e;
        inSeg = 0;
        if (expQ.size() == 0) chk(0, "R1", "unexpected bus write", 1, 0);
        else begin
          e = expQ.pop_front();
          chk(segCle == e.cle, e.tag, "cle", segCle, e.cle);
          chk(segAle == e.ale, e.tag, "ale", segAle, e.ale);
          chk(segByte == e.b, e.tag, "byte", segByte, e.b);
          chk(mPre == e.su, "R1", "write setup clocks", mPre, e.su);
          chk(mLow == e.lo, "R1", "write strobe clocks", mLow, e.lo);
          chk(mPost == e.ho, "R1", "write hold clocks", mPost, e.ho);
          chk(!ceBad, "R6", "ce low during cycle", ceBad, 0);
        end
      end
      if (!nandReN) begin
        rLow++; rIn = 1;
      end else if (rIn) begin
        int ex;
        rIn = 0;
        ex = (rdLowQ.size() != 0) ? rdLowQ.pop_front() : -1;
        chk(rLow == ex, "R2", "read strobe clocks", rLow, ex);
        rLow = 0;
      end
    end
  end

  initial begin
    logic [31:0] d;
    int s;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(nandCeN && nandWeN && nandReN && !nandCle && !nandAle && !irq && hostReady,
        "R6", "reset pin state", {nandCeN, nandWeN, nandReN, nandCle, nandAle, irq, hostReady},
        7'b1110001);

    // R1/R3/R4/R5 write cycles under two timing sets
    setTiming(1, 2, 1, 0, 0, 0, 0, 0);
    busWrite(REG_CMD, 32'hDEAD_BE5A, "R3");
    busWrite(REG_ADDR, 32'h0000_0133, "R4");
    busWrite(REG_DATA, 32'hFFFF_FF0C, "R5");
    setTiming(0, 0, 3, 1, 0, 0, 0, 0);
    busWrite(REG_CMD, 32'h0000_00FF, "R3");
    busWrite(REG_DATA, 32'h1234_5600, "R5");
    hostRead(REG_TIMING, d);
    chk(d == 32'h1030_0000, "R1", "timing readback", d, 32'h1030_0000);

    // R10 stall length
    setTiming(1, 2, 1, 3, 0, 0, 0, 0);
    busWrite(REG_ADDR, 32'h0000_00A7, "R4");
    hostWrite(REG_IEN, 32'h0, s);
    chk(s == 11, "R10", "stall clocks after write", s, 11);

    // R2/R5 read cycles
    setTiming(0, 0, 0, 0, 2, 3, 1, 0);
    nandDin = 8'hC3;
    rdLowQ.push_back(4);
    hostRead(REG_DATA, d);
    chk(d == 32'h0000_00C3, "R5", "data read value", d, 32'hC3);
    setTiming(0, 0, 0, 0, 0, 0, 2, 1);
    nandDin = 8'h7E;
    rdLowQ.push_back(1);
    hostRead(REG_DATA, d);
    chk(d == 32'h0000_007E, "R5", "data read value 2", d, 32'h7E);

    // R6 chip-enable hold
    hostWrite(REG_CFG, 32'h20, s);
    @(negedge clk);
    chk(!nandCeN, "R6", "ce forced low", nandCeN, 0);
    busWrite(REG_CMD, 32'h90, "R3");
    hostWrite(REG_CFG, 32'h0, s);
    @(negedge clk);
    chk(nandCeN, "R6", "ce released", nandCeN, 1);

    // R7 status follows ready line
    nandRdy = 1'b0;
    repeat (4) @(negedge clk);
    hostRead(REG_STAT, d);
    chk(d == 32'h0, "R7", "status busy", d, 0);
    hostRead(REG_ISTAT, d);
    chk(d == 32'h0, "R8", "no event on falling ready", d, 0);

    // R8 ready interrupt, edge triggered and gated
    hostWrite(REG_IEN, 32'h1, s);
    nandRdy = 1'b1;
    repeat (4) @(negedge clk);
    hostRead(REG_STAT, d);
    chk(d == 32'h1, "R7", "status ready", d, 1);
    hostRead(REG_ISTAT, d);
    chk(d == 32'h1, "R8", "ready event set", d, 1);
    chk(irq == 1'b1, "R8", "irq asserted", irq, 1);
    hostWrite(REG_ICLR, 32'h1, s);
    repeat (3) @(negedge clk);
    hostRead(REG_ISTAT, d);
    chk(d == 32'h0, "R8", "level does not re-raise", d, 0);
    chk(irq == 1'b0, "R8", "irq cleared", irq, 0);
    hostWrite(REG_IEN, 32'h0, s);
    nandRdy = 1'b0;
    repeat (4) @(negedge clk);
    nandRdy = 1'b1;
    repeat (4) @(negedge clk);
    hostRead(REG_ISTAT, d);
    chk(d == 32'h1, "R8", "event with enable off", d, 1);
    chk(irq == 1'b0, "R8", "irq gated", irq, 0);

    // R9 transfer count
    setTiming(0, 1, 0, 0, 0, 0, 0, 0);
    hostWrite(REG_XCOUNT, 32'h2, s);
    busWrite(REG_DATA, 32'h11, "R5");
    hostRead(REG_ISTAT, d);
    chk(d[1] == 1'b0, "R9", "no done after first", d[1], 0);
    busWrite(REG_CMD, 32'h70, "R3");
    hostRead(REG_ISTAT, d);
    chk(d[1] == 1'b0, "R9", "command cycle not counted", d[1], 0);
    busWrite(REG_DATA, 32'h22, "R5");
    hostRead(REG_ISTAT, d);
    chk(d == 32'h3, "R9", "done after second", d, 3);
    hostRead(REG_XCOUNT, d);
    chk(d == 32'h0, "R9", "count at zero", d, 0);
    hostWrite(REG_ICLR, 32'h2, s);
    hostRead(REG_ISTAT, d);
    chk(d == 32'h1, "R8", "selective clear", d, 1);

    // R11 soft reset
    hostWrite(REG_CFG, 32'h20, s);
    hostWrite(REG_IEN, 32'h3, s);
    hostWrite(REG_XCOUNT, 32'h5, s);
    hostWrite(REG_CTRL, 32'h4, s);
    @(negedge clk);
    chk(nandCeN, "R11", "ce high after reset", nandCeN, 1);
    hostRead(REG_CFG, d);
    chk(d == 32'h0, "R11", "cfg cleared", d, 0);
    hostRead(REG_IEN, d);
    chk(d == 32'h0, "R11", "enable cleared", d, 0);
    hostRead(REG_ISTAT, d);
    chk(d == 32'h0, "R11", "status cleared", d, 0);
    hostRead(REG_XCOUNT, d);
    chk(d == 32'h0, "R11", "count cleared", d, 0);
    hostRead(REG_CTRL, d);
    chk(d == 32'h0, "R11", "control self clears", d, 0);
    hostRead(REG_TIMING, d);
    chk(d == 32'h0100_0000, "R11", "timing kept", d, 32'h0100_0000);
    busWrite(REG_ADDR, 32'h5C, "R4");

    repeat (10) @(negedge clk);
    chk(expQ.size() == 0 && rdLowQ.size() == 0, "R1", "scoreboard drained",
        expQ.size() + rdLowQ.size(), 0);
    summary();
    $finish;
  end
endmodule